// File: doc/BRIEF.md
# External Bus Strobe Controller

This block drives the control strobes of a multiplexed 8-bit external memory bus. It produces the address-latch strobe (ALE), an active-low read strobe and an active-low write strobe, plus an output enable for the ALE pad. Each data access is also classified as on-chip or off-chip. The CPU core reports each bus cycle with a kind code and a 16-bit address. The block then decides whether the cycle leaves the chip. For an off-chip cycle it emits an ALE phase first and then the matching read or write pulse.

A single 8-bit auxiliary control register at bus-register address 8Eh sets the behaviour. Its fields control four things: ALE can be muted while idle, the strobe pulse has a short or a long width, the on-chip XRAM window has one of four sizes, and all data accesses can be forced off-chip. When ALE is not muted, it runs freely at one sixth of the clock rate, or one third in double-speed (X2) mode. While a long strobe is still running, the block holds off further requests with a busy output.

Top module: `ext_bus_strobe_ctrl`

## Requirements
- R1: After reset the auxiliary register reads 00h, except bit 1, which equals the `extram_por` input. In the same state `rd_n` and `wr_n` are 1 and `busy` is 0.
- R2: A write with `cfg_addr` = 8Eh stores bit 5 (stretch), bits 3:2 (XRAM size code), bit 1 (force-external) and bit 0 (ALE mute). Bits 7, 6 and 4 always read 0. A write to any other address leaves the register unchanged.
- R3: With ALE mute clear, X2 clear and no access in flight, ALE repeats every 6 clocks, is high for 2 of them, and `ale_oe` is 1.
- R4: With ALE mute clear and X2 set, ALE repeats every 3 clocks and is high for 1 of them.
- R5: With ALE mute set and no access in flight, `ale` is 0 and `ale_oe` is 0 (the pad is released to its weak pull-up).
- R6: An off-chip cycle starts in the cycle after it is accepted. It opens with an ALE-high phase of 2 clocks (1 clock in X2 mode) with `ale_oe` 1, and its read or write strobe starts only after that phase, in both ALE mute settings.
- R7: The strobe lasts 6 clocks when stretch is 0 and 30 clocks when stretch is 1, in either X2 setting. Kind 00 (data read) pulses `rd_n`, kind 01 (data write) pulses `wr_n`, and the two are never low together.
- R8: Kind 10 (table read from code) and kind 11 (code fetch) are always off-chip. They produce the ALE phase and no read or write strobe.
- R9: `ext_sel` is 1 for kinds 10 and 11. For kinds 00 and 01 it is 1 when force-external is set, or when the address is at or above (size code + 1) × 256 bytes.
- R10: A data access that stays on-chip raises no strobe and does not set `busy`.
- R11: `busy` is high from the cycle after an off-chip cycle is accepted until its strobe ends. A request presented while `busy` is high waits, and starts only after the current cycle has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| extram_por | input | 1 | Power-up value of the force-external bit |
| x2_mode | input | 1 | Double-speed mode: halves the ALE timing |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| aux_rdata | output | 8 | Current auxiliary register value |
| req_valid | input | 1 | Bus cycle request from the core |
| req_kind | input | 2 | 00 data read, 01 data write, 10 table read, 11 fetch |
| req_addr | input | 16 | Address of the requested cycle |
| busy | output | 1 | Off-chip cycle in flight; new requests wait |
| ale | output | 1 | Address-latch strobe |
| ale_oe | output | 1 | ALE pad drive enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ext_sel | output | 1 | 1 when the presented request goes off-chip |

## Verification
The bench uses the default parameters: a 6-clock slot with a 2-clock ALE phase, strobes of 6 and 30 clocks, 256-byte XRAM granules and 16-bit addresses. With these values every size code and every off-chip boundary can be swept in full, and every legal register write pattern can be tried. It also runs each data or code kind through all combinations of stretch, X2 and ALE mute. Because the long strobe is 30 clocks, a second request can be placed partway through a running strobe, and its exact wait time is then known.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

  // Cycle kinds reported by the core
  typedef enum logic [1:0] {
    KIND_XRD   = 2'b00,
    KIND_XWR   = 2'b01,
    KIND_CODE  = 2'b10,
    KIND_FETCH = 2'b11
  } cyc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ADDR = 2'b01,
    ST_STRB = 2'b10
  } bus_state_e;

  // Bit positions inside the auxiliary register
  localparam int unsigned AUX_MUTE_BIT    = 0;
  localparam int unsigned AUX_EXTRAM_BIT  = 1;
  localparam int unsigned AUX_SIZE_LO     = 2;
  localparam int unsigned AUX_SIZE_HI     = 3;
  localparam int unsigned AUX_STRETCH_BIT = 5;
  localparam logic [7:0]  AUX_WMASK       = 8'b0010_1111;

  // Length of a timing phase, halved in double-speed mode
  function automatic int unsigned slot_len(input logic x2, input int unsigned base);
    return x2 ? (base / 2) : base;
  endfunction

  // Strobe width in clocks
  function automatic int unsigned strobe_clks(input logic stretch,
                                              input int unsigned short_len,
                                              input int unsigned long_len);
    return stretch ? long_len : short_len;
  endfunction

  // First address outside the on-chip window
  function automatic logic [31:0] xram_limit(input logic [1:0] code, input int unsigned unit);
    return (32'(code) + 32'd1) * 32'(unit);
  endfunction

  // Routing decision for one request
  function automatic logic goes_external(input logic [1:0]  kind,
                                         input logic        force_ext,
                                         input logic [1:0]  code,
                                         input logic [31:0] addr,
                                         input int unsigned unit);
    logic is_data;
    is_data = (kind == KIND_XRD) || (kind == KIND_XWR);
    return !is_data || force_ext || (addr >= xram_limit(code, unit));
  endfunction

endpackage

// File: rtl/aux_cfg_reg.sv
module aux_cfg_reg
  import bus_strobe_pkg::*;
#(
  parameter logic [7:0] SFR_ADDR = 8'h8E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       extram_por,
  input  logic       cfg_we,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] aux_q,
  output logic       cfg_mute,
  output logic       cfg_extram,
  output logic [1:0] cfg_size,
  output logic       cfg_stretch
);

  logic hit;
  assign hit = cfg_we && (cfg_addr == SFR_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q <= {6'b0, extram_por, 1'b0};
    end else if (hit) begin
      aux_q <= cfg_wdata & AUX_WMASK;
    end
  end

  assign cfg_mute    = aux_q[AUX_MUTE_BIT];
  assign cfg_extram  = aux_q[AUX_EXTRAM_BIT];
  assign cfg_size    = aux_q[AUX_SIZE_HI:AUX_SIZE_LO];
  assign cfg_stretch = aux_q[AUX_STRETCH_BIT];

endmodule

// File: rtl/ale_divider.sv
module ale_divider
  import bus_strobe_pkg::*;
#(
  parameter int unsigned CYC_CLKS = 6,
  parameter int unsigned ALE_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic x2_mode,
  output logic free_ale
);

  localparam int unsigned CW = $clog2(CYC_CLKS + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_cnt;
  logic [CW-1:0] hi_len;
  logic          wrap;

  always_comb begin
    last_cnt = CW'(slot_len(x2_mode, CYC_CLKS) - 1);
    hi_len   = CW'(slot_len(x2_mode, ALE_CLKS));
  end

  // ">=" also recovers when X2 shortens the slot mid-count
  assign wrap = (cnt_q >= last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign free_ale = (cnt_q < hi_len);

endmodule

// File: rtl/strobe_fsm.sv
module strobe_fsm
  import bus_strobe_pkg::*;
#(
  parameter int unsigned ALE_CLKS   = 2,
  parameter int unsigned SHORT_STRB = 6,
  parameter int unsigned LONG_STRB  = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       x2_mode,
  input  logic       start,
  input  logic [1:0] start_kind,
  input  logic       stretch,
  output logic       busy,
  output logic       txn_ale,
  output logic       rd_n,
  output logic       wr_n
);

  localparam int unsigned MAXLEN = (LONG_STRB > ALE_CLKS) ? LONG_STRB : ALE_CLKS;
  localparam int unsigned TW     = $clog2(MAXLEN + 1);

  bus_state_e    state_q;
  logic [TW-1:0] tmr_q;
  logic [TW-1:0] strb_m1_q;
  logic [1:0]    kind_q;
  logic          tmr_done;
  logic          kind_is_data;

  assign tmr_done     = (tmr_q == '0);
  assign kind_is_data = (kind_q == KIND_XRD) || (kind_q == KIND_XWR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tmr_q     <= '0;
      strb_m1_q <= '0;
      kind_q    <= 2'b00;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q   <= ST_ADDR;
            tmr_q     <= TW'(slot_len(x2_mode, ALE_CLKS) - 1);
            strb_m1_q <= TW'(strobe_clks(stretch, SHORT_STRB, LONG_STRB) - 1);
            kind_q    <= start_kind;
          end
        end
        ST_ADDR: begin
          if (tmr_done) begin
            if (kind_is_data) begin
              state_q <= ST_STRB;
              tmr_q   <= strb_m1_q;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        ST_STRB: begin
          if (tmr_done) begin
            state_q <= ST_IDLE;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign txn_ale = (state_q == ST_ADDR);
  assign rd_n    = !((state_q == ST_STRB) && (kind_q == KIND_XRD));
  assign wr_n    = !((state_q == ST_STRB) && (kind_q == KIND_XWR));

endmodule

// File: rtl/ext_bus_strobe_ctrl.sv
module ext_bus_strobe_ctrl
  import bus_strobe_pkg::*;
#(
  parameter logic [7:0]  SFR_ADDR   = 8'h8E,
  parameter int unsigned CYC_CLKS   = 6,
  parameter int unsigned ALE_CLKS   = 2,
  parameter int unsigned SHORT_STRB = 6,
  parameter int unsigned LONG_STRB  = 30,
  parameter int unsigned XRAM_UNIT  = 256,
  parameter int unsigned ADDR_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              extram_por,
  input  logic              x2_mode,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        aux_rdata,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              ale,
  output logic              ale_oe,
  output logic              rd_n,
  output logic              wr_n,
  output logic              ext_sel
);

  logic       cfg_mute;
  logic       cfg_extram;
  logic [1:0] cfg_size;
  logic       cfg_stretch;
  logic       free_ale;
  logic       txn_ale;
  logic       accept;
  logic       req_ext;
  logic       start_ext;

  aux_cfg_reg #(.SFR_ADDR(SFR_ADDR)) cfg_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .extram_por  (extram_por),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .aux_q       (aux_rdata),
    .cfg_mute    (cfg_mute),
    .cfg_extram  (cfg_extram),
    .cfg_size    (cfg_size),
    .cfg_stretch (cfg_stretch)
  );

  ale_divider #(.CYC_CLKS(CYC_CLKS), .ALE_CLKS(ALE_CLKS)) div_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .x2_mode  (x2_mode),
    .free_ale (free_ale)
  );

  // Routing and acceptance
  assign req_ext   = goes_external(req_kind, cfg_extram, cfg_size, 32'(req_addr), XRAM_UNIT);
  assign ext_sel   = req_ext;
  assign accept    = req_valid && !busy;
  assign start_ext = accept && req_ext;

  strobe_fsm #(
    .ALE_CLKS  (ALE_CLKS),
    .SHORT_STRB(SHORT_STRB),
    .LONG_STRB (LONG_STRB)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .x2_mode    (x2_mode),
    .start      (start_ext),
    .start_kind (req_kind),
    .stretch    (cfg_stretch),
    .busy       (busy),
    .txn_ale    (txn_ale),
    .rd_n       (rd_n),
    .wr_n       (wr_n)
  );

  // An access in flight owns ALE; otherwise the free-running strobe unless muted
  assign ale    = busy ? txn_ale : (free_ale && !cfg_mute);
  assign ale_oe = busy || !cfg_mute;

endmodule

// File: rtl/ext_bus_strobe_chk.sv
module ext_bus_strobe_chk #(
  parameter int unsigned LONG_STRB = 30
) (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic ale_oe,
  input logic rd_n,
  input logic wr_n,
  input logic busy,
  input logic accept,
  input logic req_ext,
  input logic cfg_mute
);

  localparam int unsigned RW = $clog2(LONG_STRB + 2);

  logic [RW-1:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= '0;
    end else if (!rd_n || !wr_n) begin
      low_run_q <= low_run_q + 1'b1;
    end else begin
      low_run_q <= '0;
    end
  end

  // R7
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R7
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_run_q <= RW'(LONG_STRB));

  // R6
  ale_before_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> $past(ale));

  // R6
  ale_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> $past(ale));

  // R5
  ale_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mute && !busy) |-> (!ale_oe && !ale));

  // R11
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> busy);

  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_ext) |=> (busy && ale && ale_oe));

  // R10
  internal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_ext) |=> (!busy && rd_n && wr_n));

endmodule

bind ext_bus_strobe_ctrl ext_bus_strobe_chk #(.LONG_STRB(LONG_STRB)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .ale      (ale),
  .ale_oe   (ale_oe),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .busy     (busy),
  .accept   (accept),
  .req_ext  (req_ext),
  .cfg_mute (cfg_mute)
);

// File: tb/ext_bus_strobe_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_bus_strobe_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        extram_por = 1'b0;
  logic        x2_mode = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  aux_rdata;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [15:0] req_addr = 16'h0000;
  logic        busy, ale, ale_oe, rd_n, wr_n, ext_sel;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ext_bus_strobe_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .extram_por(extram_por), .x2_mode(x2_mode),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .aux_rdata(aux_rdata),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .busy(busy), .ale(ale), .ale_oe(ale_oe), .rd_n(rd_n), .wr_n(wr_n), .ext_sel(ext_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic por);
    rst_n = 1'b0;
    extram_por = por;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 aux reset", aux_rdata, por ? 8'h02 : 8'h00);
    chk("R1 rd_n reset", rd_n, 1);
    chk("R1 wr_n reset", wr_n, 1);
    chk("R1 busy reset", busy, 0);
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic measure_ale(input int exp_per, input int exp_hi, input string req);
    int n, hi, lo, oe_bad;
    n = 0;
    while (ale && n < 50) begin @(negedge clk); n++; end
    while (!ale && n < 50) begin @(negedge clk); n++; end
    hi = 0; lo = 0; oe_bad = 0;
    while (ale && hi < 50) begin if (!ale_oe) oe_bad++; hi++; @(negedge clk); end
    while (!ale && lo < 50) begin if (!ale_oe) oe_bad++; lo++; @(negedge clk); end
    chk({req, " ALE high clocks"}, hi, exp_hi);
    chk({req, " ALE period"}, hi + lo, exp_per);
    chk({req, " ale_oe held"}, oe_bad, 0);
  endtask

  // Issue one request and measure the resulting cycle at the pins
  task automatic do_txn(input logic [1:0] kind, input logic [15:0] addr, input int exp_ext,
                        input int exp_ale, input int exp_strb, input int exp_hold,
                        input string req);
    int hold, ale_n, own_n, other_n, order_bad, n;
    bit seen_strb;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = addr;
    #1;
    chk({req, " R9 ext_sel"}, ext_sel, exp_ext);
    hold = 0;
    while (busy && hold < 200) begin @(negedge clk); hold++; end
    if (exp_hold >= 0) chk("R11 wait while busy", hold, exp_hold);
    @(negedge clk);
    req_valid = 1'b0;
    ale_n = 0; own_n = 0; other_n = 0; order_bad = 0; n = 0; seen_strb = 1'b0;
    while (busy && n < 200) begin
      if (ale) begin
        ale_n++;
        if (seen_strb) order_bad++;
        if (!ale_oe) order_bad++;
      end
      if (!rd_n) begin if (kind == 2'b00) own_n++; else other_n++; seen_strb = 1'b1; if (ale) order_bad++; end
      if (!wr_n) begin if (kind == 2'b01) own_n++; else other_n++; seen_strb = 1'b1; if (ale) order_bad++; end
      n++;
      @(negedge clk);
    end
    chk({req, " R6 ALE phase clocks"}, ale_n, exp_ale);
    chk({req, " R6 ALE precedes strobe"}, order_bad, 0);
    chk({req, " R7 strobe clocks"}, own_n, exp_strb);
    chk({req, " R7 wrong strobe line"}, other_n, 0);
    if (exp_ext == 0) begin
      for (int i = 0; i < 4; i++) begin
        chk("R10 on-chip access quiet", {busy, rd_n, wr_n}, 3'b011);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog actual=hung expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1 both power-up settings
    do_reset(1'b1);
    do_reset(1'b0);

    // R2 every write pattern, reserved bits read 0
    for (int d = 0; d < 256; d++) begin
      write_reg(8'h8E, 8'(d));
      #1;
      chk("R2 register readback", aux_rdata, d & 8'h2F);
    end
    write_reg(8'h8E, 8'h26);
    write_reg(8'h8D, 8'h09);
    #1;
    chk("R2 other address ignored", aux_rdata, 8'h26);
    write_reg(8'h8F, 8'hFF);
    #1;
    chk("R2 other address ignored", aux_rdata, 8'h26);

    // R3 / R4 free-running ALE
    write_reg(8'h8E, 8'h00);
    measure_ale(6, 2, "R3");
    x2_mode = 1'b1;
    measure_ale(3, 1, "R4");
    x2_mode = 1'b0;
    measure_ale(6, 2, "R3");

    // R5 muted ALE
    write_reg(8'h8E, 8'h01);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk("R5 muted ALE released", {ale, ale_oe}, 2'b00);
    end

    // R9 routing sweep
    req_valid = 1'b0;
    for (int code = 0; code < 4; code++) begin
      for (int fe = 0; fe < 2; fe++) begin
        write_reg(8'h8E, 8'((code << 2) | (fe << 1)));
        for (int k = 0; k < 4; k++) begin
          for (int a = 0; a < 4; a++) begin
            int lim, adr, exp;
            lim = (code + 1) * 256;
            adr = (a == 0) ? 0 : (a == 1) ? lim - 1 : (a == 2) ? lim : 16'hFFFF;
            exp = (k >= 2 || fe == 1 || adr >= lim) ? 1 : 0;
            req_kind = 2'(k); req_addr = 16'(adr);
            #1;
            chk("R9 routing", ext_sel, exp);
          end
        end
      end
    end

    // R6 R7 R8 R10 across stretch, X2 and mute
    for (int st = 0; st < 2; st++) begin
      for (int x2 = 0; x2 < 2; x2++) begin
        for (int mu = 0; mu < 2; mu++) begin
          int ea, es;
          ea = x2 ? 1 : 2;
          es = st ? 30 : 6;
          x2_mode = x2[0];
          write_reg(8'h8E, 8'((st << 5) | 2 | mu));
          do_txn(2'b00, 16'h0010, 1, ea, es, 0, "R7 read");
          do_txn(2'b01, 16'h0020, 1, ea, es, 0, "R7 write");
          do_txn(2'b10, 16'h1234, 1, ea, 0, 0, "R8 table read");
          do_txn(2'b11, 16'h0000, 1, ea, 0, 0, "R8 fetch");
          write_reg(8'h8E, 8'((st << 5) | mu));
          do_txn(2'b00, 16'h0050, 0, 0, 0, 0, "R10 on-chip read");
          do_txn(2'b01, 16'h00FF, 0, 0, 0, 0, "R10 on-chip write");
          do_txn(2'b00, 16'h0100, 1, ea, es, 0, "R9 read past window");
        end
      end
    end
    x2_mode = 1'b0;

    // R11 request arrives during a long strobe
    write_reg(8'h8E, 8'h22);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b00; req_addr = 16'h0400;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    do_txn(2'b01, 16'h0401, 1, 2, 30, 2 + 30 - 3, "R11 queued write");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule